// File: doc/BRIEF.md
# Streaming systematic Reed-Solomon encoder over GF(256)

This block turns a stream of 8-bit message symbols into a 255-symbol systematic Reed-Solomon codeword. Message symbols arrive at most one per clock with a valid flag. The first symbol of a codeword is marked by a start pulse. Each accepted symbol is forwarded unchanged to the output one cycle later. At the same time it is folded into a bank of parity registers that divides the message by the code generator polynomial.

Each register stage multiplies the feedback symbol by one fixed generator coefficient. The multiplier reduces the constant coefficient through a fully unrolled shift-and-reduce chain, and the feedback bits select which of the reduced terms are summed. Once the last message symbol has been accepted, the parity registers are shifted out back to back, highest order first, and the block returns to idle with its registers cleared.

The number of parity symbols is fixed when the block is elaborated. It is 32, 16 or 8, which gives 223, 239 or 247 message symbols.

Top module: `rs_enc_systematic`

## Requirements
- R1: Field arithmetic uses the reduction polynomial x^8+x^4+x^3+x^2+1 (0x11D). The generator is the product of (x + a^j) for j = 0 .. NPAR-1 with a = 0x02. Every codeword therefore evaluates to zero at each a^j, where the first output symbol is the coefficient of x^254.
- R2: Parameter NPAR (supported values 32, 16 and 8) sets the parity count. The message length is 255-NPAR. Each codeword produces exactly 255 output symbols.
- R3: A codeword starts only when in_valid and in_sop are both high while the block is idle. in_valid without in_sop in idle produces no output. in_sop inside a codeword is ignored.
- R4: Each accepted message symbol appears unchanged on out_data, with out_valid high, in the cycle after it was accepted. A cycle with in_valid low inside the message phase produces out_valid low one cycle later.
- R5: The cycle after the last message symbol is output, the NPAR parity symbols follow on consecutive cycles. They are the remainder of x^NPAR·D(x) divided by the generator, highest-order coefficient first.
- R6: out_last is high exactly with the 255th symbol of each codeword.
- R7: in_valid, in_sop and in_data have no effect while parity symbols are being shifted out.
- R8: A new codeword may start the cycle after out_last. Its parity does not depend on any earlier codeword.
- R9: While reset is asserted, out_valid, out_last and out_data are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | in_data carries a message symbol this cycle |
| in_sop | input | 1 | Marks the first message symbol of a codeword |
| in_data | input | 8 | Message symbol |
| out_valid | output | 1 | out_data carries a codeword symbol |
| out_data | output | 8 | Codeword symbol: message first, then parity |
| out_last | output | 1 | High with the final symbol of a codeword |

## Verification
The assertions take for granted that the source never expects backpressure. Input offered during the parity window is dropped, not held. The checks on forwarded message symbols also assume in_data is a defined value whenever in_valid is high.

The stimulus respects these assumptions, yet it still drives in_valid and in_sop high, with random data, throughout one parity window. This shows that such input is discarded. It also scatters random gaps and stray start pulses through one message, and it starts one codeword the cycle right after the previous out_last.

// File: rtl/rs_enc_systematic.sv
module rs_enc_systematic #(
  parameter int          NPAR       = 32,
  parameter logic [8:0]  FIELD_POLY = 9'h11D
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_sop,
  input  logic [7:0] in_data,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_last
);
  localparam int         KMSG   = 255 - NPAR;
  localparam logic [7:0] LAST_D = 8'(KMSG - 1);
  localparam logic [7:0] LAST_P = 8'(NPAR - 1);

  // reduced operand a, selector bits b
  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r;
    logic [7:0] acc;
    r   = a;
    acc = 8'h00;
    for (int t = 0; t < 8; t++) begin
      if (b[t]) acc = acc ^ r;
      r = {r[6:0], 1'b0} ^ (r[7] ? FIELD_POLY[7:0] : 8'h00);
    end
    return acc;
  endfunction

  function automatic logic [8*NPAR-1:0] gen_coefs();
    logic [7:0]        g [0:NPAR];
    logic [7:0]        root;
    logic [8*NPAR-1:0] flat;
    for (int i = 0; i <= NPAR; i++) g[i] = 8'h00;
    g[0] = 8'h01;
    root = 8'h01;
    for (int j = 0; j < NPAR; j++) begin
      for (int i = j + 1; i > 0; i--) g[i] = g[i-1] ^ gf_mul(g[i], root);
      g[0] = gf_mul(g[0], root);
      root = gf_mul(root, 8'h02);
    end
    for (int i = 0; i < NPAR; i++) flat[8*i +: 8] = g[i];
    return flat;
  endfunction

  localparam logic [8*NPAR-1:0] GCOEF = gen_coefs();

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_PAR} state_t;

  state_t     st;
  logic [7:0] cnt;
  logic [7:0] par  [NPAR];
  logic [7:0] prod [NPAR];
  logic [7:0] fb;
  logic       accept;
  logic       par_zero;

  assign accept = in_valid && ((st == S_DATA) || (st == S_IDLE && in_sop));
  assign fb     = in_data ^ par[NPAR-1];

  for (genvar i = 0; i < NPAR; i++) begin : g_tap
    assign prod[i] = gf_mul(GCOEF[8*i +: 8], fb);
  end

  always_comb begin
    par_zero = 1'b1;
    for (int i = 0; i < NPAR; i++) if (par[i] != 8'h00) par_zero = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= 8'd0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_data  <= 8'h00;
      for (int i = 0; i < NPAR; i++) par[i] <= 8'h00;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      if (st == S_PAR) begin
        out_valid <= 1'b1;
        out_data  <= par[NPAR-1];
        for (int i = NPAR - 1; i > 0; i--) par[i] <= par[i-1];
        par[0] <= 8'h00;
        if (cnt == LAST_P) begin
          out_last <= 1'b1;
          st       <= S_IDLE;
          cnt      <= 8'd0;
        end else begin
          cnt <= cnt + 8'd1;
        end
      end else if (accept) begin
        out_valid <= 1'b1;
        out_data  <= in_data;
        par[0]    <= prod[0];
        for (int i = NPAR - 1; i > 0; i--) par[i] <= par[i-1] ^ prod[i];
        if (cnt == LAST_D) begin
          st  <= S_PAR;
          cnt <= 8'd0;
        end else begin
          st  <= S_DATA;
          cnt <= cnt + 8'd1;
        end
      end
    end
  end

  assert_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (out_valid && !out_last && out_data == $past(in_data)));

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !(in_valid && in_sop)) |=> !out_valid);

  assert_par_stream_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PAR) |=> out_valid);

  assert_last_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  assert_last_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> (par_zero && st == S_IDLE));
endmodule

// File: tb/rs_enc_systematic_tb_top.sv
module rs_enc_systematic_tb_top;
  localparam int NPAR = 32;
  localparam int KMSG = 255 - NPAR;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_sop = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_last;

  always #5 clk = ~clk;

  rs_enc_systematic #(.NPAR(NPAR)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int cyc = 0;
  always @(posedge clk) cyc++;

  logic [7:0] cap   [0:1023];
  bit         cap_l [0:1023];
  int         cap_c [0:1023];
  int         cap_n = 0;

  always @(negedge clk)
    if (rst_n && out_valid && cap_n < 1024) begin
      cap[cap_n]   = out_data;
      cap_l[cap_n] = out_last;
      cap_c[cap_n] = cyc;
      cap_n++;
    end

  int gen [0:NPAR];
  int exp_cw [0:254];
  logic [7:0] d_a [255];
  logic [7:0] d_b [255];

  function automatic int tb_mul(input int a, input int b);
    int p = 0;
    while (b != 0) begin
      if ((b & 1) != 0) p ^= a;
      a = a << 1;
      if ((a & 256) != 0) a ^= 'h11D;
      b = b >> 1;
    end
    return p;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic build_exp(input logic [7:0] d [255]);
    int m [0:254];
    for (int n = 0; n < 255; n++) m[n] = (n < KMSG) ? int'(d[n]) : 0;
    for (int n = 0; n < KMSG; n++) begin
      int c = m[n];
      if (c != 0)
        for (int i = 0; i <= NPAR; i++) m[n+i] ^= tb_mul(c, gen[NPAR-i]);
    end
    for (int n = 0; n < 255; n++) exp_cw[n] = (n < KMSG) ? int'(d[n]) : m[n];
  endtask

  task automatic verify(input int base, input string preq);
    int bad = -1;
    int nl = 0;
    int nz = 0;
    int aj = 1;
    for (int n = 0; n < KMSG; n++)
      if (bad < 0 && int'(cap[base+n]) != exp_cw[n]) bad = n;
    chk(bad < 0, "R4", "message symbol", (bad < 0) ? 0 : int'(cap[base+bad]),
        (bad < 0) ? 0 : exp_cw[bad]);
    bad = -1;
    for (int n = KMSG; n < 255; n++)
      if (bad < 0 && int'(cap[base+n]) != exp_cw[n]) bad = n;
    chk(bad < 0, preq, "parity symbol", (bad < 0) ? 0 : int'(cap[base+bad]),
        (bad < 0) ? 0 : exp_cw[bad]);
    for (int n = 0; n < 255; n++) if (cap_l[base+n]) nl++;
    chk(cap_l[base+254] && nl == 1, "R6", "out_last count/position", nl, 1);
    for (int j = 0; j < NPAR; j++) begin
      int s = 0;
      for (int n = 0; n < 255; n++) s = tb_mul(s, aj) ^ int'(cap[base+n]);
      if (s != 0) nz++;
      aj = tb_mul(aj, 2);
    end
    chk(nz == 0, "R1", "nonzero syndromes", nz, 0);
  endtask

  task automatic send(input logic [7:0] d [255], input bit gaps, input bit sop_noise,
                      input bit lat_chk, input bit inject);
    for (int i = 0; i < KMSG; i++) begin
      if (gaps && i > 0)
        repeat ($urandom_range(0, 2)) begin
          @(negedge clk);
          in_valid = 1'b0;
          in_sop   = 1'($urandom_range(0, 1));
          in_data  = 8'($urandom);
        end
      @(negedge clk);
      in_valid = 1'b1;
      in_sop   = (i == 0) || (sop_noise && $urandom_range(0, 3) == 0);
      in_data  = d[i];
      if (lat_chk && i == 0) begin
        @(negedge clk);
        chk(out_valid && out_data == d[0], "R4", "first symbol one cycle later",
            int'(out_data), int'(d[0]));
        in_valid = 1'b0;
        in_sop   = 1'b0;
        @(negedge clk);
        chk(!out_valid, "R4", "out_valid after gap", int'(out_valid), 0);
      end
    end
    if (inject) begin
      repeat (NPAR) begin
        @(negedge clk);
        in_valid = 1'b1;
        in_sop   = 1'b1;
        in_data  = 8'($urandom);
      end
    end else begin
      @(negedge clk);
      in_valid = 1'b0;
      in_sop   = 1'b0;
    end
  endtask

  task automatic quiet();
    @(negedge clk);
    in_valid = 1'b0;
    in_sop   = 1'b0;
  endtask

  task automatic wait_cap(input int n);
    int t = 0;
    while (cap_n < n && t < 5000) begin
      @(negedge clk);
      t++;
    end
    repeat (4) @(negedge clk);
    chk(cap_n == n, "R2", "symbols per run", cap_n, n);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    int root = 1;
    void'($urandom(32'd715));
    for (int i = 0; i <= NPAR; i++) gen[i] = 0;
    gen[0] = 1;
    for (int j = 0; j < NPAR; j++) begin
      for (int i = j + 1; i > 0; i--) gen[i] = gen[i-1] ^ tb_mul(gen[i], root);
      gen[0] = tb_mul(gen[0], root);
      root = tb_mul(root, 2);
    end

    repeat (3) @(negedge clk);
    chk(!out_valid && !out_last && out_data == 8'h00, "R9", "outputs in reset",
        int'({out_valid, out_last, out_data}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // stray valid in idle without start pulse
    repeat (5) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sop   = 1'b0;
      in_data  = 8'($urandom);
    end
    quiet();
    repeat (3) @(negedge clk);
    chk(cap_n == 0, "R3", "output without start pulse", cap_n, 0);

    // incrementing message 1..k
    for (int i = 0; i < 255; i++) d_a[i] = 8'(i + 1);
    cap_n = 0;
    build_exp(d_a);
    send(d_a, 1'b0, 1'b0, 1'b1, 1'b0);
    wait_cap(255);
    verify(0, "R5");

    // random message with gaps and stray start pulses
    for (int i = 0; i < 255; i++) d_a[i] = 8'($urandom);
    cap_n = 0;
    build_exp(d_a);
    send(d_a, 1'b1, 1'b1, 1'b0, 1'b0);
    wait_cap(255);
    verify(0, "R3");

    // all-zero message
    for (int i = 0; i < 255; i++) d_a[i] = 8'h00;
    cap_n = 0;
    build_exp(d_a);
    send(d_a, 1'b0, 1'b0, 1'b0, 1'b0);
    wait_cap(255);
    verify(0, "R5");

    // all-ones message with input during parity, then back-to-back codeword
    for (int i = 0; i < 255; i++) begin
      d_a[i] = 8'hFF;
      d_b[i] = 8'($urandom);
    end
    cap_n = 0;
    send(d_a, 1'b0, 1'b0, 1'b0, 1'b1);
    send(d_b, 1'b0, 1'b0, 1'b0, 1'b0);
    quiet();
    wait_cap(510);
    build_exp(d_a);
    verify(0, "R7");
    build_exp(d_b);
    verify(255, "R8");
    chk(cap_c[255] == cap_c[254] + 1, "R8", "cycle gap to next codeword",
        cap_c[255] - cap_c[254], 1);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule